// File: doc/BRIEF.md
# Clock Frequency Measurement Counter

This block measures how fast an on-chip clock runs. Software picks one of a bank of test clocks and a window length in periods of a slow reference clock, which is nominally 32.768 kHz. It first pulses a counter-clear bit and then sets a start bit. The block opens a gate in the reference domain for the chosen number of reference periods. It brings that gate into the selected clock's domain through a two-flop synchronizer and counts rising edges of the selected clock while the gate is open. When the gate closes, the block hands the final count back to the register bus.

Software polls a busy flag in the status word. Once the flag clears, the edge count in the same word is valid. The frequency is the count multiplied by the reference frequency, divided by the window length. That conversion belongs to software. There are two registers: a control word at offset 0x0 and a status word at offset 0x4. The control word carries the enables, the source selector, the window length, the clear bit and the start bit.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, the control word at offset 0x0 reads 0 and the status word at offset 0x4 reads 0.
- R2: Control bits [WIN_W-1:0] (bits 8:0 by default) hold the window length minus one, in reference-clock periods. For a selected clock of period P, the gate window is D = (field+1) reference periods, and the reported count N satisfies |N·P − D| ≤ P. This holds for field values of 0, 15 and 100.
- R3: Control bits [14+SEL_W-1:14] (bits 19:14 by default) pick the measured clock as src_clk[field]. Any index from 0 to 2^SEL_W−1 can be selected, including 2, 5, 18, 36 and 37.
- R4: A start is accepted only if the same control write has both bit 23 and bit 13 set. If either is clear, busy stays 0 and the status count does not change.
- R5: Writing control bit 10 as 1 clears the edge counter in the measured domain. It also clears the status count to 0 in the cycle after the write.
- R6: A start is a control write that has bit 9 at 1 while the stored bit 9 is 0. Status bit 31 (busy) reads 1 from the next bus cycle on. It stays 1 until the count for that window is in status bits [23:0].
- R7: While busy is 1, a second start is ignored. Writes that change the selector or window field leave the running measurement using the values captured at its start.
- R8: The count sits zero-extended in status bits [23:0], and bits 30:24 read 0. While busy is 0 and no clear is written, the status word holds still.
- R9: The edge counter saturates at all ones (2^CNT_W−1) instead of wrapping.
- R10: The control word reads back the written value masked to its defined bits: 8:0, 9, 10, 13, 19:14 and 23. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Active-low asynchronous reset, all domains |
| ref_clk | input | 1 | Slow reference clock that times the gate |
| src_clk | input | 2^SEL_W | Bank of selectable clocks under test |
| bus_wr | input | 1 | Write strobe, one bus cycle |
| bus_addr | input | ADDR_W | Register byte offset (0x0 control, 0x4 status) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions check the following on every cycle:
- a valid start raises busy;
- a start without both enables leaves busy low;
- the captured selector and window stay frozen while busy;
- the idle result stays stable;
- the reference-domain window counter stays within the captured length;
- the counter never leaves its saturated value unless a clear arrives.

Only the bench scenarios can show that counts across several clock periods and window lengths land within one edge of the ideal value, that a start or a retune attempted mid-measurement does not disturb the result, and that a clear zeroes a non-zero count.

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int SEL_W  = 6,
  parameter int WIN_W  = 9,
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 4,
  localparam int NSRC  = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic [NSRC-1:0]   src_clk,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int START_B = 9;
  localparam int CLR_B   = 10;
  localparam int OE_B    = 13;
  localparam int SEL_LO  = 14;
  localparam int EN_B    = 23;
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [31:0] CTRL_MASK =
      32'((64'd1 << WIN_W) - 64'd1) | (32'd1 << START_B) | (32'd1 << CLR_B) |
      (32'd1 << OE_B) | (32'((64'd1 << SEL_W) - 64'd1) << SEL_LO) | (32'd1 << EN_B);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [31:0]      ctrl_q;
  logic [SEL_W-1:0] sel_s;
  logic [WIN_W-1:0] win_s;
  logic             busy_q, req_tgl;
  logic [CNT_W-1:0] result_q;
  logic             dn_s1, dn_s2, dn_s3;
  logic             rq_s1, rq_s2, rq_s3;
  logic             gate_r;
  logic [WIN_W-1:0] rcnt;
  logic             g_m1, g_m2, g_m3, c_m1, c_m2, done_tgl;
  logic [CNT_W-1:0] cnt_m;
  logic [23:0]      res24;

  wire wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  wire en_ok    = bus_wdata[EN_B] & bus_wdata[OE_B];
  wire start_go = wr_ctrl & bus_wdata[START_B] & ~ctrl_q[START_B] & en_ok & ~busy_q;
  wire done_evt = dn_s2 ^ dn_s3;
  wire rq_evt   = rq_s2 ^ rq_s3;
  wire mclk     = src_clk[sel_s];

  assign res24 = 24'(result_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sel_s    <= '0;
      win_s    <= '0;
      busy_q   <= 1'b0;
      req_tgl  <= 1'b0;
      result_q <= '0;
      dn_s1    <= 1'b0;
      dn_s2    <= 1'b0;
      dn_s3    <= 1'b0;
    end else begin
      dn_s1 <= done_tgl;
      dn_s2 <= dn_s1;
      dn_s3 <= dn_s2;
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (start_go) begin
        sel_s   <= bus_wdata[SEL_LO +: SEL_W];
        win_s   <= bus_wdata[WIN_W-1:0];
        req_tgl <= ~req_tgl;
        busy_q  <= 1'b1;
      end else if (done_evt) begin
        busy_q <= 1'b0;
      end
      if (wr_ctrl && bus_wdata[CLR_B]) result_q <= '0;
      else if (done_evt)               result_q <= cnt_m;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)      bus_rdata = ctrl_q;
    else if (bus_addr == A_STAT) bus_rdata = {busy_q, 7'd0, res24};
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_s1  <= 1'b0;
      rq_s2  <= 1'b0;
      rq_s3  <= 1'b0;
      gate_r <= 1'b0;
      rcnt   <= '0;
    end else begin
      rq_s1 <= req_tgl;
      rq_s2 <= rq_s1;
      rq_s3 <= rq_s2;
      if (rq_evt) begin
        gate_r <= 1'b1;
        rcnt   <= win_s;
      end else if (gate_r) begin
        if (rcnt == '0) gate_r <= 1'b0;
        else            rcnt   <= rcnt - WIN_W'(1);
      end
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      g_m1     <= 1'b0;
      g_m2     <= 1'b0;
      g_m3     <= 1'b0;
      c_m1     <= 1'b0;
      c_m2     <= 1'b0;
      done_tgl <= 1'b0;
      cnt_m    <= '0;
    end else begin
      g_m1 <= gate_r;
      g_m2 <= g_m1;
      g_m3 <= g_m2;
      c_m1 <= ctrl_q[CLR_B];
      c_m2 <= c_m1;
      if (c_m2)                         cnt_m <= '0;
      else if (g_m2 && cnt_m != CNT_MAX) cnt_m <= cnt_m + CNT_W'(1);
      if (g_m3 && !g_m2) done_tgl <= ~done_tgl;
    end
  end

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[START_B] && !ctrl_q[START_B] && bus_wdata[EN_B] &&
     bus_wdata[OE_B] && !busy_q) |=> busy_q);

  // R4
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !(bus_wdata[EN_B] && bus_wdata[OE_B]) && !busy_q) |=> !busy_q);

  // R7
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(sel_s) && $stable(win_s)));

  // R8
  idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !$past(busy_q) && !$past(wr_ctrl && bus_wdata[CLR_B])) |-> $stable(result_q));

  // R2
  win_bound_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    gate_r |-> (rcnt <= win_s));

  // R9
  saturate_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (cnt_m == CNT_MAX && !c_m2) |=> (cnt_m == CNT_MAX));

endmodule

// File: tb/test_clk_freq_meter.sv
module test_clk_freq_meter;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = 12;
  localparam longint TREF_PS = 200000;

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  wire  [63:0] src_clk;

  int vectors = 0, miscompares = 0, cyc = 0, start_cyc = -100;
  bit mdl_idle = 1'b1, finished = 1'b0;
  logic [31:0] mdl_ctrl = '0;
  logic [23:0] mdl_cnt = '0;

  function automatic int hp_ps(int g);
    return 2000 + 700 * (g % 13);
  endfunction

  always #2.5 clk = ~clk;
  always #100 ref_clk = ~ref_clk;

  for (genvar g = 0; g < 64; g++) begin : g_src
    logic c = 1'b0;
    initial forever #(real'(hp_ps(g)) / 1000.0) c = ~c;
    assign src_clk[g] = c;
  end

  clk_freq_meter #(.CNT_W(CW)) i_clk_freq_meter (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .src_clk(src_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic check(string tag, longint act, longint exp, bit ok);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 180000);
      report();
    end
    #1;
    if (rst_n && bus_addr == 4'd4) begin
      if (!mdl_idle && cyc - start_cyc >= 1 && cyc - start_cyc <= 20)
        check("R6 busy after start", bus_rdata[31], 1, bus_rdata[31] == 1'b1);
      else if (mdl_idle)
        check("R8 idle status", bus_rdata, {8'd0, mdl_cnt}, bus_rdata == {8'd0, mdl_cnt});
    end
  end

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = d;
    if (d[10] && mdl_idle) mdl_cnt = '0;
    if (d[9] && !mdl_ctrl[9] && d[23] && d[13] && mdl_idle) begin
      mdl_idle = 1'b0;
      start_cyc = cyc;
    end
    mdl_ctrl = d;
    @(posedge clk);
    #0.5;
    bus_wr = 1'b0; bus_addr = 4'd4;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
    bus_addr = 4'd4;
  endtask

  task automatic measure(int sid, int win, string tag, bit retune, bit sat);
    logic [31:0] base, v;
    longint per, d, diff;
    int n;
    base = (32'd1 << 23) | (32'd1 << 13) | (32'(sid) << 14) | 32'(win);
    wr(base | (32'd1 << 10));
    repeat (40) @(negedge clk);
    wr(base);
    repeat (40) @(negedge clk);
    wr(base | (32'd1 << 9));
    if (retune) begin
      repeat (10) @(negedge clk);
      wr((32'd1 << 23) | (32'd1 << 13) | (32'd18 << 14) | 32'd15);
      wr((32'd1 << 23) | (32'd1 << 13) | (32'd18 << 14) | 32'd15 | (32'd1 << 9));
    end
    n = 0;
    do begin
      rd(4'd4, v);
      n++;
    end while (v[31] && n < 60000);
    per = 2 * longint'(hp_ps(sid));
    d = longint'(win + 1) * TREF_PS;
    diff = longint'(v[23:0]) * per - d;
    if (diff < 0) diff = -diff;
    if (sat)
      check({tag, " saturated count"}, v[23:0], (1 << CW) - 1, v[23:0] == 24'((1 << CW) - 1));
    else
      check(tag, v[23:0], d / per, diff <= per && v[31] == 1'b0);
    mdl_cnt = v[23:0];
    mdl_idle = 1'b1;
    wr(base);
  endtask

  initial begin
    logic [31:0] v, exp_mask, hold;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    rd(4'd0, v); check("R1 control after reset", v, 0, v == 0);
    rd(4'd4, v); check("R1 status after reset", v, 0, v == 0);

    exp_mask = 32'h1FF | (32'd1 << 9) | (32'd1 << 10) | (32'd1 << 13) | (32'h3F << 14) | (32'd1 << 23);
    wr(32'hFF7F_FFFF);
    rd(4'd0, v); check("R10 control readback", v, 32'hFF7F_FFFF & exp_mask, v == (32'hFF7F_FFFF & exp_mask));
    wr(32'd0);

    measure(37, 15, "R2 R3 src 37 window 16", 0, 0);
    measure(2, 100, "R2 R3 src 2 window 101", 0, 0);
    measure(5, 0, "R2 R3 src 5 window 1", 0, 0);
    measure(18, 15, "R3 src 18 window 16", 0, 0);
    measure(36, 7, "R3 src 36 window 8", 0, 0);

    hold = {8'd0, mdl_cnt};
    wr((32'd1 << 13) | (32'd5 << 14) | 32'd3);
    wr((32'd1 << 13) | (32'd5 << 14) | 32'd3 | (32'd1 << 9));
    repeat (100) @(negedge clk);
    rd(4'd4, v); check("R4 start without bit 23", v, hold, v == hold);
    wr(32'd0);
    wr((32'd1 << 23) | (32'd5 << 14) | 32'd3 | (32'd1 << 9));
    repeat (100) @(negedge clk);
    rd(4'd4, v); check("R4 start without bit 13", v, hold, v == hold);
    wr(32'd0);

    measure(2, 9, "R7 retune and restart while busy", 1, 0);

    wr(32'd1 << 10);
    rd(4'd4, v); check("R5 clear zeroes count", v, 0, v == 0);
    wr(32'd0);

    measure(0, 511, "R9", 0, 1);

    repeat (20) @(negedge clk);
    report();
  end
endmodule